// File: doc/BRIEF.md
# Tagged Command Queue Engine

This block sits on the host side of a storage link and turns a ring of command entries in memory into register writes on the device. Software fills 32-byte request entries and moves a request in-pointer forward. The engine reads each pending entry one 32-bit word at a time, and replays the encoded register/value halfwords it finds onto the device's shadow-register write port. It then waits for the device to signal completion with a status byte.

For each finished command the engine writes one 8-byte response entry. The response carries the command tag, a small engine status, the device status and a timestamp. The engine then advances both its request out-pointer and its response in-pointer. Both rings have 32 entries. Only the index field of each pointer is engine state. The rest of each address comes from the pointer or the base that software supplies.

Top module: `tcq_engine`

## Requirements
- R1: After reset the engine is idle, both ring indices are 0, and none of `mem_rd_req`, `dev_wr_en` or `rsp_wr_en` is asserted.
- R2: The request ring is empty when the index field `req_in_ptr[9:5]` equals the out-pointer index. The engine leaves idle and issues a read only when `enable` is 1 and the ring is not empty. Otherwise it issues no read and stays idle.
- R3: Every entry at index i is read at the base address `{req_in_ptr[31:10], i, 5'b0}`, and `req_in_ptr[4:0]` is ignored.
  - Only the words at byte offsets 8, 12, 16 and so on are read, in ascending order. A new read is issued only after the previous word has returned.
  - Reading stops with the word that holds the entry's last register halfword.
  - The low halfword of the word at offset 8 is the flag word. The register halfwords follow in little-endian halfword order.
- R4: Each register halfword gives one device write, one per cycle, in entry order. The register address is halfword bits [10:8] and the data byte is bits [7:0]. The list ends after the halfword with bit 15 set, or after the 11th halfword, and no further write follows.
- R5: The command tag is flag bits [5:1]. Flag bit 0 set marks a device-to-host (read) command.
- R6: Exactly one response is written per entry. It is written in the cycle after `dev_done` is sampled high, never earlier.
- R7: Response layout:
  - bits [15:0] hold the tag, zero-extended;
  - bits [23:16] hold the engine status, with bit 16 = error and bit 17 = read command, all other bits 0;
  - bits [31:24] hold the device status;
  - bits [63:32] hold the timestamp.
- R8: The error bit is set exactly when the device status has any of bits 7, 5, 3 or 0 set. Bits 6, 4, 2 and 1 do not set it.
- R9: The timestamp is a free-running 32-bit count of the clock cycles since reset, sampled in the cycle the response is written.
- R10: Ring pointers and response addresses:
  - After a response, both indices increase by one, wrapping from 31 to 0, and no other address bit changes.
  - `req_out_ptr` equals `{req_in_ptr[31:10], out index, 5'b0}`.
  - A response is written to `{rsp_base[31:8], response index, 3'b0}`, and `rsp_base[7:0]` is ignored.
- R11: When `enable` is cleared mid-entry, that entry still runs to its response, after which the engine goes idle and fetches nothing. Setting `enable` again resumes with the next pending entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows the engine to start new entries |
| req_in_ptr | input | 32 | Request in-pointer advanced by software |
| rsp_base | input | 32 | Response ring base (bits [31:8] used) |
| req_out_ptr | output | 32 | Request out-pointer |
| rsp_in_ptr | output | 32 | Response in-pointer |
| idle | output | 1 | Engine is not working on an entry |
| mem_rd_req | output | 1 | Word read request, one cycle |
| mem_rd_addr | output | 32 | Byte address of the word to read |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Read data word |
| dev_wr_en | output | 1 | Device shadow-register write strobe |
| dev_wr_reg | output | 3 | Shadow-register address |
| dev_wr_data | output | 8 | Shadow-register data byte |
| dev_done | input | 1 | Device completion strobe |
| dev_status | input | 8 | Device status byte, valid with `dev_done` |
| rsp_wr_en | output | 1 | Response entry write strobe |
| rsp_wr_addr | output | 32 | Response entry byte address |
| rsp_wr_data | output | 64 | Response entry contents |

## Verification
The assertions rely on three properties of the inputs:
- Memory returns exactly one word for each read it is given.
- The device pulses `dev_done` once per command and only after the command write.
- Software never moves the in-pointer a full ring ahead of the out-pointer.

The bench keeps to these rules. Its memory model answers each read exactly once, a cycle later. Its device model raises a single completion pulse a set delay after seeing the command-register write. Its software side never has more than 30 entries outstanding.

// File: rtl/tcq_pkg.sv
package tcq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_EMIT,
        ST_CMPL,
        ST_RESP
    } tcq_state_e;

    // device status bits that mark a failed command: busy, fault, data request, error
    localparam logic [7:0] DEV_BAD_MASK = 8'hA9;

    // word of a request entry holding the flag halfword
    localparam int unsigned FLAG_WORD = 2;

    function automatic logic [7:0] eng_status(input logic [7:0] dstat, input logic rd);
        return {6'b0, rd, |(dstat & DEV_BAD_MASK)};
    endfunction

endpackage

// File: rtl/tcq_ring_index.sv
module tcq_ring_index #(
    parameter int unsigned IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (step) idx_d = idx_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign idx = idx_q;
endmodule

// File: rtl/tcq_stamp.sv
module tcq_stamp #(
    parameter int unsigned TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] count
);
    logic [TS_W-1:0] cnt_d, cnt_q;

    always_comb cnt_d = cnt_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/tcq_slot_decode.sv
module tcq_slot_decode (
    input  logic [31:0] word,
    input  logic        sel_hi,
    output logic [2:0]  reg_addr,
    output logic [7:0]  data,
    output logic        last
);
    logic [15:0] hw;
    logic        unused_hw;

    always_comb begin
        hw       = sel_hi ? word[31:16] : word[15:0];
        reg_addr = hw[10:8];
        data     = hw[7:0];
        last     = hw[15];
    end

    assign unused_hw = ^hw[14:11];
endmodule

// File: rtl/tcq_engine.sv
module tcq_engine #(
    parameter int unsigned AW      = 32,
    parameter int unsigned IDX_W   = 5,
    parameter int unsigned REQ_LSB = 5,
    parameter int unsigned RSP_LSB = 3,
    parameter int unsigned NREG    = 11,
    parameter int unsigned TS_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [AW-1:0]     req_in_ptr,
    input  logic [AW-1:0]     rsp_base,
    output logic [AW-1:0]     req_out_ptr,
    output logic [AW-1:0]     rsp_in_ptr,
    output logic              idle,
    output logic              mem_rd_req,
    output logic [AW-1:0]     mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [31:0]       mem_rd_data,
    output logic              dev_wr_en,
    output logic [2:0]        dev_wr_reg,
    output logic [7:0]        dev_wr_data,
    input  logic              dev_done,
    input  logic [7:0]        dev_status,
    output logic              rsp_wr_en,
    output logic [AW-1:0]     rsp_wr_addr,
    output logic [TS_W+31:0]  rsp_wr_data
);
    import tcq_pkg::*;

    localparam int unsigned SLOT_W = $clog2(NREG + 1);
    localparam int unsigned REQ_HI = REQ_LSB + IDX_W;
    localparam int unsigned RSP_HI = RSP_LSB + IDX_W;
    localparam int unsigned TAG_W  = 5;

    typedef struct packed {
        tcq_state_e        st;
        logic [SLOT_W-1:0] slot;
        logic [31:0]       word;
        logic [TAG_W-1:0]  tag;
        logic              rd;
        logic [7:0]        dstat;
    } seq_t;

    seq_t r_d, r_q;

    logic [IDX_W-1:0] in_idx, out_idx, rsp_idx;
    logic             step_d;
    logic [TS_W-1:0]  stamp;
    logic [2:0]       dec_reg;
    logic [7:0]       dec_data;
    logic             dec_last;
    logic [AW-1:0]    word_off;
    logic             unused_bits;

    assign in_idx      = req_in_ptr[REQ_HI-1:REQ_LSB];
    assign unused_bits = ^{req_in_ptr[REQ_LSB-1:0], rsp_base[RSP_HI-1:0]};

    tcq_ring_index #(.IDX_W(IDX_W)) i_req_idx (
        .clk(clk), .rst_n(rst_n), .step(step_d), .idx(out_idx)
    );

    tcq_ring_index #(.IDX_W(IDX_W)) i_rsp_idx (
        .clk(clk), .rst_n(rst_n), .step(step_d), .idx(rsp_idx)
    );

    tcq_stamp #(.TS_W(TS_W)) i_stamp (
        .clk(clk), .rst_n(rst_n), .count(stamp)
    );

    tcq_slot_decode i_dec (
        .word(r_q.word), .sel_hi(r_q.slot[0]),
        .reg_addr(dec_reg), .data(dec_data), .last(dec_last)
    );

    always_comb begin
        r_d    = r_q;
        step_d = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (enable && (in_idx != out_idx)) begin
                    r_d.st   = ST_FETCH;
                    r_d.slot = '0;
                end
            end
            ST_FETCH: r_d.st = ST_WAIT;
            ST_WAIT: begin
                if (mem_rd_valid) begin
                    r_d.word = mem_rd_data;
                    r_d.st   = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (r_q.slot == '0) begin
                    r_d.tag  = dec_data[5:1];
                    r_d.rd   = dec_data[0];
                    r_d.slot = SLOT_W'(1);
                end else if (dec_last || (r_q.slot == SLOT_W'(NREG))) begin
                    r_d.st = ST_CMPL;
                end else begin
                    r_d.slot = r_q.slot + 1'b1;
                    if (r_q.slot[0]) r_d.st = ST_FETCH;
                end
            end
            ST_CMPL: begin
                if (dev_done) begin
                    r_d.dstat = dev_status;
                    r_d.st    = ST_RESP;
                end
            end
            ST_RESP: begin
                step_d = 1'b1;
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign word_off    = AW'(FLAG_WORD) + AW'(r_q.slot >> 1);
    assign req_out_ptr = {req_in_ptr[AW-1:REQ_HI], out_idx, {REQ_LSB{1'b0}}};
    assign rsp_in_ptr  = {rsp_base[AW-1:RSP_HI], rsp_idx, {RSP_LSB{1'b0}}};
    assign idle        = (r_q.st == ST_IDLE);
    assign mem_rd_req  = (r_q.st == ST_FETCH);
    assign mem_rd_addr = req_out_ptr + (word_off << 2);
    assign dev_wr_en   = (r_q.st == ST_EMIT) && (r_q.slot != '0);
    assign dev_wr_reg  = dec_reg;
    assign dev_wr_data = dec_data;
    assign rsp_wr_en   = (r_q.st == ST_RESP);
    assign rsp_wr_addr = rsp_in_ptr;
    assign rsp_wr_data = {stamp, r_q.dstat, eng_status(r_q.dstat, r_q.rd),
                          {(16 - TAG_W){1'b0}}, r_q.tag};

    // R2: leaving idle needs enable and a non-empty ring one cycle earlier
    a_r2_start_needs_work: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(!idle) |-> ($past(enable) && ($past(in_idx) != $past(out_idx))));

    // R3: a single read outstanding, never two requests back to back
    a_r3_one_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);

    // R4: nothing is written after the terminating halfword
    a_r4_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_wr_en && dec_last) |=> !dev_wr_en);

    // R6: a response only follows a sampled completion
    a_r6_resp_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wr_en |-> $past(dev_done));

    // R10: both indices step by one after a response
    a_r10_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wr_en |=> ((rsp_idx == $past(rsp_idx) + 1'b1) && (out_idx == $past(out_idx) + 1'b1)));

    // R11: disabled and idle stays idle
    a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && idle) |=> idle);

endmodule

// File: tb/test_tcq_engine.sv
module test_tcq_engine;

    localparam logic [31:0] REQ_BASE = 32'h8123_4000;
    localparam logic [31:0] RSP_BASE = 32'h4567_89F8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [31:0] req_in_ptr;
    logic [31:0] rsp_base = RSP_BASE;
    logic [31:0] req_out_ptr, rsp_in_ptr;
    logic        idle;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        dev_wr_en;
    logic [2:0]  dev_wr_reg;
    logic [7:0]  dev_wr_data;
    logic        dev_done = 1'b0;
    logic [7:0]  dev_status = '0;
    logic        rsp_wr_en;
    logic [31:0] rsp_wr_addr;
    logic [63:0] rsp_wr_data;

    tcq_engine i_tcq_engine (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .req_in_ptr(req_in_ptr), .rsp_base(rsp_base),
        .req_out_ptr(req_out_ptr), .rsp_in_ptr(rsp_in_ptr), .idle(idle),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .dev_wr_en(dev_wr_en), .dev_wr_reg(dev_wr_reg), .dev_wr_data(dev_wr_data),
        .dev_done(dev_done), .dev_status(dev_status),
        .rsp_wr_en(rsp_wr_en), .rsp_wr_addr(rsp_wr_addr), .rsp_wr_data(rsp_wr_data)
    );

    always #4 clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    logic [31:0] mem [0:255];
    logic [15:0] ent_regs [0:10];
    int sw_idx = 0;
    int first_idx = 0;
    int cyc = 0;

    logic [15:0] exp_wr [0:255];
    int exp_n = 0;
    int exp_tag [0:63];
    bit exp_rd [0:63];
    int exp_nr [0:63];
    int exp_e = 0;

    logic [10:0] wr_log [0:255];
    int wr_n = 0;
    logic [31:0] rd_log [0:255];
    int rd_n = 0;
    logic [31:0] rsp_addr_log [0:63];
    logic [63:0] rsp_data_log [0:63];
    int ts_log [0:63];
    int rsp_n = 0;

    logic [7:0] dev_stat_arr [0:63];
    int dn = 0;
    int dcnt = 0;
    int dev_delay = 2;

    bit rd_pend = 0;
    logic [31:0] rd_pa;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // memory model: one word per read, returned on the following cycle
    always @(negedge clk) begin
        mem_rd_valid = 1'b0;
        if (rd_pend) begin
            mem_rd_valid = 1'b1;
            mem_rd_data  = mem[rd_pa[9:2]];
            rd_pend      = 0;
        end
        if (mem_rd_req) begin
            rd_pend = 1;
            rd_pa   = mem_rd_addr;
            rd_log[rd_n] = mem_rd_addr;
            rd_n++;
        end
    end

    // device model: completes a set delay after the command-register write
    always @(negedge clk) begin
        dev_done = 1'b0;
        if (dcnt > 0) begin
            dcnt--;
            if (dcnt == 0) begin
                dev_done   = 1'b1;
                dev_status = dev_stat_arr[dn];
                dn++;
            end
        end
        if (dev_wr_en) begin
            wr_log[wr_n] = {dev_wr_reg, dev_wr_data};
            wr_n++;
            if (dev_wr_reg == 3'd7) dcnt = dev_delay;
        end
        if (rsp_wr_en) begin
            rsp_addr_log[rsp_n] = rsp_wr_addr;
            rsp_data_log[rsp_n] = rsp_wr_data;
            ts_log[rsp_n]       = cyc;
            rsp_n++;
        end
    end

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input int r, input int d, input bit last);
        return {last, 4'b0, 3'(r), 8'(d)};
    endfunction

    task automatic clear_logs();
        wr_n = 0; rd_n = 0; rsp_n = 0; exp_n = 0; exp_e = 0; dn = 0;
        first_idx = sw_idx;
    endtask

    task automatic publish();
        req_in_ptr = {REQ_BASE[31:10], 5'(sw_idx), 5'h0B};
    endtask

    task automatic add_entry(input int tag, input bit rd, input int nr, input logic [7:0] st);
        logic [15:0] hw [0:11];
        int base = (sw_idx % 32) * 8;
        for (int s = 0; s < 12; s++)
            hw[s] = (s == 0) ? 16'((tag << 1) | int'(rd)) : ((s <= nr) ? ent_regs[s-1] : 16'h0);
        mem[base]     = 32'hC0DE_0000 | 32'(sw_idx);
        mem[base + 1] = 32'h0;
        for (int w = 0; w < 6; w++) mem[base + 2 + w] = {hw[2*w+1], hw[2*w]};
        for (int k = 0; k < nr; k++) begin exp_wr[exp_n] = ent_regs[k]; exp_n++; end
        exp_tag[exp_e] = tag; exp_rd[exp_e] = rd; exp_nr[exp_e] = nr;
        dev_stat_arr[exp_e] = st;
        exp_e++;
        sw_idx++;
    endtask

    task automatic short_regs();
        ent_regs[0] = mk(2, 1, 0);
        ent_regs[1] = mk(7, 8'hC8, 1);
    endtask

    task automatic drain();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (idle && (req_out_ptr[9:5] == 5'(sw_idx))) break;
        end
    endtask

    task automatic compare_all();
        int ri = 0;
        chk("R4", "write count", 64'(wr_n), 64'(exp_n));
        for (int k = 0; k < exp_n && k < wr_n; k++)
            chk("R4", "write reg/data", 64'(wr_log[k]), 64'(exp_wr[k][10:0]));
        chk("R6", "response count", 64'(rsp_n), 64'(exp_e));
        for (int e = 0; e < exp_e && e < rsp_n; e++) begin
            logic [7:0] st = dev_stat_arr[e];
            bit err = st[7] | st[5] | st[3] | st[0];
            logic [4:0] idx = 5'(first_idx + e);
            chk("R5", "tag", 64'(rsp_data_log[e][15:0]), 64'(exp_tag[e]));
            chk("R8", "engine status", 64'(rsp_data_log[e][23:16]), 64'({6'b0, exp_rd[e], err}));
            chk("R7", "device status", 64'(rsp_data_log[e][31:24]), 64'(st));
            chk("R9", "timestamp", 64'(rsp_data_log[e][63:32]), 64'(ts_log[e]));
            chk("R10", "response address", 64'(rsp_addr_log[e]), 64'({RSP_BASE[31:8], idx, 3'b0}));
            for (int w = 0; w <= exp_nr[e] / 2; w++) begin
                chk("R3", "read address", 64'(rd_log[ri]),
                    64'({REQ_BASE[31:10], idx, 5'b0} + 32'(8 + 4 * w)));
                ri++;
            end
        end
        chk("R3", "read count", 64'(rd_n), 64'(ri));
    endtask

    task automatic t_reset();
        chk("R1", "idle", 64'(idle), 64'(1));
        chk("R1", "out pointer", 64'(req_out_ptr), 64'({REQ_BASE[31:10], 10'b0}));
        chk("R1", "response pointer", 64'(rsp_in_ptr), 64'({RSP_BASE[31:8], 8'b0}));
        chk("R1", "strobes", 64'({mem_rd_req, dev_wr_en, rsp_wr_en}), 64'(0));
    endtask

    task automatic t_basic();
        clear_logs();
        ent_regs[0] = mk(2, 8'h08, 0); ent_regs[1] = mk(1, 0, 0);
        ent_regs[2] = mk(3, 8'h10, 0); ent_regs[3] = mk(4, 8'h20, 0);
        ent_regs[4] = mk(5, 8'h30, 0); ent_regs[5] = mk(6, 8'hE0, 0);
        ent_regs[6] = mk(7, 8'hC8, 1);
        add_entry(3, 1, 7, 8'h50);
        publish();
        drain();
        compare_all();
        chk("R10", "out index after one", 64'(req_out_ptr[9:5]), 64'(1));
    endtask

    task automatic t_full();
        clear_logs();
        ent_regs[0] = mk(2, 8'h00, 0); ent_regs[1] = mk(2, 8'h08, 0);
        ent_regs[2] = mk(1, 8'h00, 0); ent_regs[3] = mk(3, 8'h11, 0);
        ent_regs[4] = mk(3, 8'h22, 0); ent_regs[5] = mk(4, 8'h33, 0);
        ent_regs[6] = mk(4, 8'h44, 0); ent_regs[7] = mk(5, 8'h55, 0);
        ent_regs[8] = mk(5, 8'h66, 0); ent_regs[9] = mk(6, 8'hE0, 0);
        ent_regs[10] = mk(7, 8'h35, 1);
        add_entry(17, 0, 11, 8'h51);
        publish();
        drain();
        compare_all();
    endtask

    task automatic t_status_bits();
        clear_logs();
        short_regs();
        for (int b = 0; b < 8; b++) add_entry(8 + b, b[0], 2, 8'(1 << b));
        publish();
        drain();
        compare_all();
    endtask

    task automatic t_wrap();
        clear_logs();
        short_regs();
        for (int k = 0; k < 30; k++) add_entry(k % 32, 0, 2, 8'h50);
        publish();
        drain();
        compare_all();
        chk("R10", "out index wrapped", 64'(req_out_ptr[9:5]), 64'(5'(sw_idx)));
        chk("R10", "response index wrapped", 64'(rsp_in_ptr), 64'({RSP_BASE[31:8], 5'(sw_idx), 3'b0}));
    endtask

    task automatic t_empty();
        clear_logs();
        enable = 1'b1;
        repeat (30) @(negedge clk);
        chk("R2", "reads on empty ring", 64'(rd_n), 64'(0));
        chk("R2", "idle on empty ring", 64'(idle), 64'(1));
        enable = 1'b0;
        short_regs();
        add_entry(21, 1, 2, 8'h58);
        publish();
        repeat (40) @(negedge clk);
        chk("R2", "reads while disabled", 64'(rd_n), 64'(0));
        chk("R11", "responses while disabled", 64'(rsp_n), 64'(0));
        chk("R2", "idle while disabled", 64'(idle), 64'(1));
        enable = 1'b1;
        drain();
        compare_all();
    endtask

    task automatic t_disable();
        clear_logs();
        dev_delay = 20;
        short_regs();
        for (int k = 0; k < 3; k++) add_entry(24 + k, 0, 2, 8'h50);
        publish();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (wr_n > 0) break;
        end
        enable = 1'b0;
        repeat (150) @(negedge clk);
        chk("R11", "responses after disable", 64'(rsp_n), 64'(1));
        chk("R11", "reads after disable", 64'(rd_n), 64'(2));
        chk("R11", "idle after disable", 64'(idle), 64'(1));
        chk("R11", "out index after disable", 64'(req_out_ptr[9:5]), 64'(5'(first_idx + 1)));
        enable = 1'b1;
        drain();
        compare_all();
        dev_delay = 2;
    endtask

    initial begin
        req_in_ptr = {REQ_BASE[31:10], 5'd0, 5'h0B};
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        enable = 1'b1;
        t_basic();
        t_full();
        t_status_bits();
        t_wrap();
        t_empty();
        t_disable();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule